// File: doc/BRIEF.md
# Vectored Interrupt Aggregator

This block merges a set of interrupt request lines (32 by default) into one interrupt line toward a processor. Software reaches its eight-word register bank through a simple single-cycle bus with a byte address, write and read strobes, write data and read data. Each request line is fixed at build time as edge-captured or level-following. Captured requests sit in a status register. Enabled requests appear in a derived pending word. A priority encoder reports the lowest-numbered pending line as a vector.

Software enables lines through atomic set and clear aliases, which avoids read-modify-write races. It acknowledges edge-captured lines by writing ones to the acknowledge word. A master word holds two separate controls. One lets the hardware lines update status. The other lets pending requests drive the output.

Top module: `irqc_top`

## Requirements
- R1: Reset (`rst` high at a clock edge) clears status, enable and master to zero; afterwards pending reads 0, vector reads 0xFFFFFFFF and `irq_o` is low.
- R2: The pending word (byte address 0x04) always reads the bitwise AND of status (0x00) and enable (0x08).
- R3: The vector word (0x18) reads the index of the lowest-numbered set pending bit, or 0xFFFFFFFF when no bit is pending.
- R4: `irq_o` is high only when master bit 0 (output enable) is 1, master bit 1 (hardware enable) is 1, and pending is nonzero.
- R5: A write to the acknowledge address (0x0C) clears exactly the status bits whose data bit is 1.
- R6: A write to 0x10 ORs the data into enable, and a write to 0x14 clears the enable bits where the data is 1; both addresses read as zero, as does 0x0C.
- R7: While master bit 1 is 0, changes on `irq_in` leave status unchanged and `irq_o` stays low.
- R8: A level-type line (its `KIND` bit is 0) sets its status bit when the input rises and clears it when the input falls.
- R9: An edge-type line (its `KIND` bit is 1) sets its status bit on a rising input; a falling input leaves the bit set until it is acknowledged.
- R10: Writes to status (0x00), enable (0x08) and master (0x1C) store the data, and these words read back what was stored. Writes to pending (0x04) and vector (0x18) leave no trace, because those words are always recomputed.
- R11: Byte addresses at or above 0x20 read as zero, and writes to them change nothing.
- R12: When a hardware line event and a register write touch the same status bit in the same cycle, the hardware event decides that bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W (8) | Byte address; bits [1:0] are ignored |
| bus_wr | input | 1 | Write strobe, takes effect at the clock edge |
| bus_rd | input | 1 | Read strobe; read data is valid in the same cycle |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, zero when no read is active |
| irq_in | input | N_SRC (32) | Interrupt request lines, synchronous to `clk` |
| irq_o | output | 1 | Interrupt output toward the processor |

## Verification
A wrong bit in the status, enable or master word appears at the ports in the very next cycle. It shows in the pending and vector reads, and in `irq_o`, because all three are computed without further registers. A corrupted edge-detect history is less visible. It shows only when a line changes. The fault then appears one cycle later, either as a status bit that is missed or as a spurious one, and an edge-type line keeps that wrong bit until it is acknowledged. The bench therefore reads status one cycle after every input change, and it also drives an input change in the same cycle as a colliding write.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    // Word index inside the bank; order is fixed by software's register map.
    typedef enum logic [2:0] {
        IDX_STATUS  = 3'd0,
        IDX_PENDING = 3'd1,
        IDX_ENABLE  = 3'd2,
        IDX_ACK     = 3'd3,
        IDX_SET_EN  = 3'd4,
        IDX_CLR_EN  = 3'd5,
        IDX_VECTOR  = 3'd6,
        IDX_MASTER  = 3'd7
    } reg_idx_e;

    localparam int BANK_WORDS  = 8;
    localparam int MASTER_W    = 2;
    localparam int MASTER_OUT  = 0;  // output enable bit
    localparam int MASTER_HW   = 1;  // hardware input enable bit

    // Decoded write strobes, one per register with a write effect.
    typedef struct packed {
        logic status;
        logic ack;
        logic enable;
        logic set_en;
        logic clr_en;
        logic master;
    } wr_strobe_t;

    function automatic wr_strobe_t decode_write(input logic wr, input logic in_range,
                                                input reg_idx_e idx);
        wr_strobe_t s;
        s        = '0;
        if (wr && in_range) begin
            s.status = (idx == IDX_STATUS);
            s.ack    = (idx == IDX_ACK);
            s.enable = (idx == IDX_ENABLE);
            s.set_en = (idx == IDX_SET_EN);
            s.clr_en = (idx == IDX_CLR_EN);
            s.master = (idx == IDX_MASTER);
        end
        return s;
    endfunction

endpackage

// File: rtl/irqc_capture.sv
// Turns request-line activity into per-bit set/clear events for the status word.
module irqc_capture #(
    parameter int                N_SRC = 32,
    parameter logic [N_SRC-1:0]  KIND  = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hw_en,
    input  logic [N_SRC-1:0] irq_in,
    output logic [N_SRC-1:0] ev_set,
    output logic [N_SRC-1:0] ev_clr
);
    logic [N_SRC-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= irq_in;
    end

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        if (KIND[i]) begin : g_edge
            // R9: only a rising input sets the bit; nothing clears it here
            assign ev_set[i] = hw_en & irq_in[i] & ~prev_q[i];
            assign ev_clr[i] = 1'b0;
        end else begin : g_level
            // R8: the bit follows each change of the input
            logic chg;
            assign chg       = irq_in[i] ^ prev_q[i];
            assign ev_set[i] = hw_en & chg & irq_in[i];
            assign ev_clr[i] = hw_en & chg & ~irq_in[i];
        end
    end
endmodule

// File: rtl/irqc_regs.sv
// Status, enable and master storage.
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int N_SRC = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  wr_strobe_t          wr_s,
    input  logic [N_SRC-1:0]    wdata,
    input  logic [MASTER_W-1:0] wmaster,
    input  logic [N_SRC-1:0]    ev_set,
    input  logic [N_SRC-1:0]    ev_clr,
    output logic [N_SRC-1:0]    status_q,
    output logic [N_SRC-1:0]    enable_q,
    output logic [MASTER_W-1:0] master_q
);
    logic [N_SRC-1:0] status_sw;
    logic [N_SRC-1:0] status_d;
    logic [N_SRC-1:0] enable_d;

    always_comb begin
        status_sw = status_q;
        if (wr_s.status) status_sw = wdata;             // R10
        if (wr_s.ack)    status_sw = status_q & ~wdata; // R5
        // R12: hardware events are applied after the software effect
        status_d  = (status_sw & ~ev_clr) | ev_set;

        enable_d  = enable_q;
        if (wr_s.enable) enable_d = wdata;              // R10
        if (wr_s.set_en) enable_d = enable_q | wdata;   // R6
        if (wr_s.clr_en) enable_d = enable_q & ~wdata;  // R6
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            enable_q <= '0;
            master_q <= '0;
        end else begin
            status_q <= status_d;
            enable_q <= enable_d;
            if (wr_s.master) master_q <= wmaster;
        end
    end
endmodule

// File: rtl/irqc_prio.sv
// Lowest-index-first encoder; all ones when nothing is pending.
module irqc_prio #(
    parameter int N_SRC  = 32,
    parameter int DATA_W = 32
) (
    input  logic [N_SRC-1:0]  pend,
    output logic [DATA_W-1:0] vec
);
    always_comb begin
        vec = '1;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (pend[i]) vec = DATA_W'(i);
        end
    end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int               N_SRC  = 32,
    parameter int               DATA_W = 32,
    parameter int               ADDR_W = 8,
    parameter logic [N_SRC-1:0] KIND   = 32'hFFFF_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N_SRC-1:0]  irq_in,
    output logic              irq_o
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0]   word;
    logic                in_range;
    reg_idx_e            idx;
    wr_strobe_t          wr_s;
    logic [N_SRC-1:0]    ev_set, ev_clr;
    logic [N_SRC-1:0]    stat_q, enab_q, pend_w;
    logic [MASTER_W-1:0] mast_q;
    logic [DATA_W-1:0]   vec_w;

    assign word     = bus_addr[ADDR_W-1:2];
    assign in_range = (int'(word) < BANK_WORDS);   // R11
    assign idx      = reg_idx_e'(word[2:0]);
    assign wr_s     = decode_write(bus_wr, in_range, idx);

    irqc_capture #(.N_SRC(N_SRC), .KIND(KIND)) u_cap (
        .clk    (clk),
        .rst    (rst),
        .hw_en  (mast_q[MASTER_HW]),   // R7
        .irq_in (irq_in),
        .ev_set (ev_set),
        .ev_clr (ev_clr)
    );

    irqc_regs #(.N_SRC(N_SRC)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_s     (wr_s),
        .wdata    (bus_wdata[N_SRC-1:0]),
        .wmaster  (bus_wdata[MASTER_W-1:0]),
        .ev_set   (ev_set),
        .ev_clr   (ev_clr),
        .status_q (stat_q),
        .enable_q (enab_q),
        .master_q (mast_q)
    );

    assign pend_w = stat_q & enab_q;   // R2

    irqc_prio #(.N_SRC(N_SRC), .DATA_W(DATA_W)) u_prio (
        .pend (pend_w),
        .vec  (vec_w)                  // R3
    );

    // R4, R7
    assign irq_o = mast_q[MASTER_OUT] & mast_q[MASTER_HW] & (|pend_w);

    always_comb begin
        bus_rdata = '0;
        if (bus_rd && in_range) begin
            unique case (idx)
                IDX_STATUS:  bus_rdata = DATA_W'(stat_q);
                IDX_PENDING: bus_rdata = DATA_W'(pend_w);
                IDX_ENABLE:  bus_rdata = DATA_W'(enab_q);
                IDX_VECTOR:  bus_rdata = vec_w;
                IDX_MASTER:  bus_rdata = DATA_W'(mast_q);
                default:     bus_rdata = '0;   // R6: alias words read zero
            endcase
        end
    end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
    import irqc_pkg::*;
#(
    parameter int               N_SRC  = 32,
    parameter int               DATA_W = 32,
    parameter int               ADDR_W = 8,
    parameter logic [N_SRC-1:0] KIND   = '0
) (
    input logic                clk,
    input logic                rst,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_wr,
    input logic                bus_rd,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic [DATA_W-1:0]   bus_rdata,
    input logic [N_SRC-1:0]    irq_in,
    input logic                irq_o,
    input logic [N_SRC-1:0]    stat_q,
    input logic [N_SRC-1:0]    enab_q,
    input logic [N_SRC-1:0]    pend_w,
    input logic [MASTER_W-1:0] mast_q,
    input logic [DATA_W-1:0]   vec_w
);
    localparam int IW = (N_SRC > 1) ? $clog2(N_SRC) : 1;

    logic             oor;
    logic             wr_ack, wr_stat, wr_set;
    logic [N_SRC-1:0] below;

    assign oor     = (bus_addr[ADDR_W-1:2] >= (ADDR_W-2)'(BANK_WORDS));
    assign wr_ack  = bus_wr && !oor && (bus_addr[4:2] == 3'd3);
    assign wr_stat = bus_wr && !oor && (bus_addr[4:2] == 3'd0);
    assign wr_set  = bus_wr && !oor && (bus_addr[4:2] == 3'd4);
    assign below   = pend_w & ((N_SRC'(1) << vec_w[IW-1:0]) - N_SRC'(1));

    a_r7_out_low_hw_off: assert property (@(posedge clk) disable iff (rst)
        !mast_q[MASTER_HW] |-> !irq_o);

    a_r4_out_needs_pending: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (pend_w != '0) && mast_q[MASTER_OUT]);

    a_r3_vec_none: assert property (@(posedge clk) disable iff (rst)
        (pend_w == '0) |-> (vec_w == '1));

    a_r3_vec_lowest: assert property (@(posedge clk) disable iff (rst)
        (pend_w != '0) |-> (pend_w[vec_w[IW-1:0]] && below == '0));

    a_r11_oor_read_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && oor) |-> (bus_rdata == '0));

    a_r6_set_enable: assert property (@(posedge clk) disable iff (rst)
        wr_set |=> ((enab_q & $past(bus_wdata[N_SRC-1:0])) == $past(bus_wdata[N_SRC-1:0])));

    for (genvar i = 0; i < N_SRC; i++) begin : g_edge_chk
        if (KIND[i]) begin : g_e
            a_r9_edge_capture: assert property (@(posedge clk) disable iff (rst)
                (mast_q[MASTER_HW] && irq_in[i] && !$past(irq_in[i])) |=> stat_q[i]);
            a_r9_edge_hold: assert property (@(posedge clk) disable iff (rst)
                (stat_q[i] && !(wr_ack && bus_wdata[i]) && !wr_stat) |=> stat_q[i]);
        end
    end
endmodule

bind irqc_top irqc_checker #(
    .N_SRC(N_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .KIND(KIND)
) u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in), .irq_o(irq_o),
    .stat_q(stat_q), .enab_q(enab_q), .pend_w(pend_w), .mast_q(mast_q), .vec_w(vec_w)
);

// File: tb/irqc_top_tb.sv
`timescale 1ns/1ps
module irqc_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] irq_in = '0;
    logic        irq_o;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;   // 250 MHz

    irqc_top #(.N_SRC(32), .DATA_W(32), .ADDR_W(8), .KIND(32'hFFFF_0000)) u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in), .irq_o(irq_o)
    );

    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } step_t;

    localparam int NSTEP = 25;
    localparam step_t STEPS [0:NSTEP-1] = '{
        '{1'b1, 8'h1C, 32'h0000_0003, 32'h0, 4'd10}, // R10 master on
        '{1'b1, 8'h08, 32'h0000_00F0, 32'h0, 4'd10}, // R10 enable store
        '{1'b1, 8'h10, 32'h0001_0001, 32'h0, 4'd6},  // R6 set-enable
        '{1'b0, 8'h08, 32'h0, 32'h0001_00F1, 4'd6},
        '{1'b1, 8'h14, 32'h0000_00F0, 32'h0, 4'd6},  // R6 clear-enable
        '{1'b0, 8'h08, 32'h0, 32'h0001_0001, 4'd6},
        '{1'b0, 8'h10, 32'h0, 32'h0000_0000, 4'd6},  // R6 alias reads zero
        '{1'b1, 8'h00, 32'h0001_0003, 32'h0, 4'd10}, // R10 status store
        '{1'b0, 8'h00, 32'h0, 32'h0001_0003, 4'd10},
        '{1'b0, 8'h04, 32'h0, 32'h0001_0001, 4'd2},  // R2
        '{1'b0, 8'h18, 32'h0, 32'h0000_0000, 4'd3},  // R3
        '{1'b1, 8'h0C, 32'h0000_0001, 32'h0, 4'd5},  // R5 ack bit 0
        '{1'b0, 8'h00, 32'h0, 32'h0001_0002, 4'd5},
        '{1'b0, 8'h04, 32'h0, 32'h0001_0000, 4'd2},
        '{1'b0, 8'h18, 32'h0, 32'h0000_0010, 4'd3},
        '{1'b1, 8'h04, 32'hFFFF_FFFF, 32'h0, 4'd10}, // R10 pending write
        '{1'b0, 8'h04, 32'h0, 32'h0001_0000, 4'd10},
        '{1'b1, 8'h18, 32'h0000_0005, 32'h0, 4'd10}, // R10 vector write
        '{1'b0, 8'h18, 32'h0, 32'h0000_0010, 4'd10},
        '{1'b1, 8'h20, 32'hFFFF_FFFF, 32'h0, 4'd11}, // R11 out of range
        '{1'b0, 8'h20, 32'h0, 32'h0000_0000, 4'd11},
        '{1'b0, 8'h00, 32'h0, 32'h0001_0002, 4'd11},
        '{1'b1, 8'h0C, 32'hFFFF_FFFF, 32'h0, 4'd5},  // R5 ack all
        '{1'b0, 8'h18, 32'h0, 32'hFFFF_FFFF, 4'd3},
        '{1'b0, 8'h1C, 32'h0, 32'h0000_0003, 4'd10}
    };

    task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b0; bus_rd = 1'b1;
        #1 check(bus_rdata, exp, tag);
    endtask

    task automatic drive_in(input logic [31:0] v);
        @(negedge clk);
        irq_in = v; bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        #1 check({31'd0, irq_o}, {31'd0, exp}, tag);
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        // R1 reset state
        rd(8'h00, 32'h0, "R1 status");
        rd(8'h08, 32'h0, "R1 enable");
        rd(8'h1C, 32'h0, "R1 master");
        rd(8'h04, 32'h0, "R1 pending");
        rd(8'h18, 32'hFFFF_FFFF, "R1 vector");
        chk_irq(1'b0, "R1 irq");

        for (int k = 0; k < NSTEP; k++) begin
            if (STEPS[k].wr) wr(STEPS[k].addr, STEPS[k].data);
            else rd(STEPS[k].addr, STEPS[k].exp, $sformatf("R%0d table step %0d", STEPS[k].req, k));
        end

        // R8 level line follows input
        wr(8'h10, 32'hFFFF_FFFF);
        drive_in(32'h0000_0004);
        rd(8'h00, 32'h0000_0004, "R8 level rise");
        chk_irq(1'b1, "R4 irq with pending");
        rd(8'h18, 32'h0000_0002, "R3 vector level");
        drive_in(32'h0);
        rd(8'h00, 32'h0, "R8 level fall");
        chk_irq(1'b0, "R4 irq none pending");

        // R9 edge line holds
        drive_in(32'h0010_0000);
        rd(8'h00, 32'h0010_0000, "R9 edge rise");
        drive_in(32'h0);
        rd(8'h00, 32'h0010_0000, "R9 edge held after fall");

        // R7 hardware enable off
        wr(8'h1C, 32'h1);
        chk_irq(1'b0, "R7 irq low hw off");
        drive_in(32'h0000_0008);
        rd(8'h00, 32'h0010_0000, "R7 input ignored");
        drive_in(32'h0);
        wr(8'h1C, 32'h2);
        chk_irq(1'b0, "R4 irq low output off");
        wr(8'h1C, 32'h3);
        chk_irq(1'b1, "R4 irq both on");

        // R5 ack and R12 collision
        wr(8'h0C, 32'h0010_0000);
        rd(8'h00, 32'h0, "R5 ack edge");
        drive_in(32'h0020_0000);
        drive_in(32'h0);
        @(negedge clk);
        irq_in = 32'h0020_0000; bus_addr = 8'h0C; bus_wdata = 32'h0020_0000;
        bus_wr = 1'b1; bus_rd = 1'b0;
        rd(8'h00, 32'h0020_0000, "R12 rise beats ack");

        // R3 priority order
        drive_in(32'h0);
        wr(8'h0C, 32'hFFFF_FFFF);
        wr(8'h00, 32'h4000_0020);
        rd(8'h18, 32'h0000_0005, "R3 lowest of two");
        wr(8'h0C, 32'h0000_0020);
        rd(8'h18, 32'h0000_001E, "R3 after ack");

        // R1 reset mid-run
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0; rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        rd(8'h00, 32'h0, "R1 status after rerun reset");
        rd(8'h1C, 32'h0, "R1 master after rerun reset");
        rd(8'h18, 32'hFFFF_FFFF, "R1 vector after rerun reset");
        chk_irq(1'b0, "R1 irq after rerun reset");

        summary();
    end
endmodule